// File: doc/BRIEF.md
# Serial Back-Channel Message Accumulator

A terminal returns status and key data to its host as a slow serial stream on an attention line, one bit per scan line. This block takes one bit from that line each time the scan-line strobe fires. It assembles the bits into a 16-bit high word and a 16-bit low word. It finds the end of the message from marker bits that travel through the words, so it needs no bit counter. When a message is complete, the block pulses a valid flag and holds both words until the consumer acknowledges them with a clear pulse.

The high word fills first. Leading zeros on the line pass through it unnoticed. The first 1 received acts as the start bit, and the high word is full once that start bit has moved down to bit 0. Every shift into the high word loads the low word with a single sentinel bit at its top. After the high word is full, bits move into the low word and push the sentinel downwards. The message is complete when the sentinel reaches bit 7, which takes eight further bits.

The controller has three states. In HUNT the high word is filling. In TAIL the low word is filling. In POSTED the message is held. The transitions are:
- HUNT to TAIL (`fill_done`): a strobe that moves the start bit into bit 0 of the high word.
- TAIL to POSTED (`msg_done`): a strobe that moves the sentinel into bit 7 of the low word.
- POSTED to HUNT (`consumed`): a clear pulse.

Top module: `bkch_accum`

## Requirements
- R1: A synchronous active-high reset clears both words to 0x0000 and the valid flag to 0. After reset the controller is in HUNT.
- R2: A cycle without a strobe leaves both words unchanged in HUNT and in TAIL. Exactly one attention bit is taken per strobe.
- R3: In HUNT, each strobe shifts the high word right by one and puts the attention bit into bit 15, where a high line gives a 1. After a start bit and 15 data bits, the high word reads {data, 1}, and the first data bit received sits at bit 1.
- R4: Every strobe that shifts the high word loads the low word with 0x8000.
- R5: Once bit 0 of the high word is 1, strobes shift the low word right and put the attention bit into bit 15 of the low word. The high word stays unchanged.
- R6: The eighth low-word strobe completes the message. On the following cycle, and for that one cycle only, msg_valid is 1. At that point the low word holds the eight bits in bits 15..8, with the first one received at bit 8. Bit 7 is set as the posted marker, and bits 6..0 are 0.
- R7: In POSTED, both words hold steady, strobes are ignored and msg_valid stays 0 until the clear pulse.
- R8: A clear pulse in POSTED sets the high word to 0x0000 and returns the controller to HUNT, so the next message is accumulated from scratch.
- R9: A clear pulse in HUNT or TAIL has no effect on either word or on the message being built.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | One-cycle strobe, one per scan line; takes one attention bit |
| attn_bit | input | 1 | Serial attention line |
| consume_clr | input | 1 | One-cycle pulse from the consumer after it reads a posted message |
| msg_hi | output | 16 | High message word |
| msg_lo | output | 16 | Low message word |
| msg_valid | output | 1 | One-cycle pulse on message completion |

## Verification
All results are registered. Both words change on the clock edge that samples a strobe, and msg_valid rises on that same edge. The valid pulse therefore appears one cycle after the completing strobe and is gone one cycle later. The bench drives every input on the falling edge and samples on the next falling edge, which is half a cycle after the edge that makes the result visible. The valid flag is checked on that falling edge and again on the following one.

// File: rtl/bkch_pkg.sv
package bkch_pkg;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_TAIL   = 2'd1,
        ST_POSTED = 2'd2
    } bkch_state_t;

    typedef enum logic [1:0] {
        OP_HOLD       = 2'd0,
        OP_SHIFT      = 2'd1,
        OP_SHIFT_MARK = 2'd2,
        OP_LOAD       = 2'd3
    } sr_op_t;

endpackage

// File: rtl/bkch_shreg.sv
module bkch_shreg
    import bkch_pkg::*;
#(
    parameter int W        = 16,
    parameter int MARK_POS = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  sr_op_t       op,
    input  logic         din,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] MARK_MASK = {{(W-1){1'b0}}, 1'b1} << MARK_POS;

    logic [W-1:0] q_r;
    logic [W-1:0] shifted;

    assign shifted = {din, q_r[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else begin
            unique case (op)
                OP_HOLD:       q_r <= q_r;
                OP_SHIFT:      q_r <= shifted;
                OP_SHIFT_MARK: q_r <= shifted | MARK_MASK;
                OP_LOAD:       q_r <= load_val;
                default:       q_r <= q_r;
            endcase
        end
    end

    assign q = q_r;

endmodule

// File: rtl/bkch_ctrl.sv
module bkch_ctrl
    import bkch_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        stb,
    input  logic        clr,
    input  logic        hi_fill_next,
    input  logic        lo_hit_next,
    output bkch_state_t state,
    output sr_op_t      hi_op,
    output sr_op_t      lo_op,
    output logic        valid
);

    bkch_state_t st_q, st_d;
    logic        valid_q;
    logic        done_now;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_HUNT;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HUNT:   if (stb && hi_fill_next) st_d = ST_TAIL;   // fill_done
            ST_TAIL:   if (stb && lo_hit_next)  st_d = ST_POSTED; // msg_done
            ST_POSTED: if (clr)                 st_d = ST_HUNT;   // consumed
            default:   st_d = ST_HUNT;
        endcase
    end

    // shift-register commands
    always_comb begin
        hi_op = OP_HOLD;
        lo_op = OP_HOLD;
        unique case (st_q)
            ST_HUNT: begin
                if (stb) begin
                    hi_op = OP_SHIFT;
                    lo_op = OP_LOAD;
                end
            end
            ST_TAIL: begin
                if (stb) begin
                    lo_op = lo_hit_next ? OP_SHIFT_MARK : OP_SHIFT;
                end
            end
            ST_POSTED: begin
                if (clr) begin
                    hi_op = OP_LOAD;
                end
            end
            default: begin
                hi_op = OP_HOLD;
                lo_op = OP_HOLD;
            end
        endcase
    end

    assign done_now = (st_q == ST_TAIL) && stb && lo_hit_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= done_now;
        end
    end

    assign state = st_q;
    assign valid = valid_q;

endmodule

// File: rtl/bkch_accum.sv
module bkch_accum
    import bkch_pkg::*;
#(
    parameter int HI_W     = 16,
    parameter int LO_W     = 16,
    parameter int TAIL_LEN = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sample_stb,
    input  logic            attn_bit,
    input  logic            consume_clr,
    output logic [HI_W-1:0] msg_hi,
    output logic [LO_W-1:0] msg_lo,
    output logic            msg_valid
);

    localparam int MARK_POS = LO_W - 1 - TAIL_LEN;
    localparam logic [LO_W-1:0] SENTINEL = {1'b1, {(LO_W-1){1'b0}}};

    bkch_state_t     st;
    sr_op_t          hi_op, lo_op;
    logic [HI_W-1:0] hi_q;
    logic [LO_W-1:0] lo_q;

    bkch_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .stb          (sample_stb),
        .clr          (consume_clr),
        .hi_fill_next (hi_q[1]),
        .lo_hit_next  (lo_q[MARK_POS+1]),
        .state        (st),
        .hi_op        (hi_op),
        .lo_op        (lo_op),
        .valid        (msg_valid)
    );

    bkch_shreg #(.W(HI_W), .MARK_POS(0)) u_hi (
        .clk      (clk),
        .rst      (rst),
        .op       (hi_op),
        .din      (attn_bit),
        .load_val ('0),
        .q        (hi_q)
    );

    bkch_shreg #(.W(LO_W), .MARK_POS(MARK_POS)) u_lo (
        .clk      (clk),
        .rst      (rst),
        .op       (lo_op),
        .din      (attn_bit),
        .load_val (SENTINEL),
        .q        (lo_q)
    );

    assign msg_hi = hi_q;
    assign msg_lo = lo_q;

endmodule

// File: rtl/bkch_accum_chk.sv
module bkch_accum_chk
    import bkch_pkg::*;
#(
    parameter int HI_W     = 16,
    parameter int LO_W     = 16,
    parameter int MARK_POS = 7
) (
    input logic            clk,
    input logic            rst,
    input logic            sample_stb,
    input logic            consume_clr,
    input logic [HI_W-1:0] msg_hi,
    input logic [LO_W-1:0] msg_lo,
    input logic            msg_valid,
    input bkch_state_t     state
);

    localparam logic [LO_W-1:0] SENT = {1'b1, {(LO_W-1){1'b0}}};

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sample_stb && state != ST_POSTED) |=> ($stable(msg_hi) && $stable(msg_lo)));

    // R4
    sentinel_load_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HUNT && sample_stb) |=> (msg_lo == SENT));

    // R5
    tail_hi_full_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TAIL) |-> msg_hi[0]);

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |=> !msg_valid);

    // R6
    posted_marker_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_lo[MARK_POS] && msg_hi[0] && state == ST_POSTED));

    // R7
    posted_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POSTED && !consume_clr) |=> ($stable(msg_hi) && $stable(msg_lo) && !msg_valid));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POSTED && consume_clr) |=> (msg_hi == '0 && state == ST_HUNT));

endmodule

bind bkch_accum bkch_accum_chk #(
    .HI_W     (HI_W),
    .LO_W     (LO_W),
    .MARK_POS (MARK_POS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sample_stb  (sample_stb),
    .consume_clr (consume_clr),
    .msg_hi      (msg_hi),
    .msg_lo      (msg_lo),
    .msg_valid   (msg_valid),
    .state       (st)
);

// File: tb/bkch_accum_bench.sv
`timescale 1ns/1ps
module bkch_accum_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_stb = 1'b0;
    logic        attn_bit = 1'b0;
    logic        consume_clr = 1'b0;
    logic [15:0] msg_hi;
    logic [15:0] msg_lo;
    logic        msg_valid;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bkch_accum u_bkch_accum (
        .clk         (clk),
        .rst         (rst),
        .sample_stb  (sample_stb),
        .attn_bit    (attn_bit),
        .consume_clr (consume_clr),
        .msg_hi      (msg_hi),
        .msg_lo      (msg_lo),
        .msg_valid   (msg_valid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        sample_stb = 1'b1;
        attn_bit   = b;
        @(negedge clk);
        sample_stb = 1'b0;
        attn_bit   = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        consume_clr = 1'b1;
        @(negedge clk);
        consume_clr = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp_hi, exp_lo, hold_hi, hold_lo;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(msg_hi == 16'h0 && msg_lo == 16'h0 && !msg_valid, "R1 reset", {msg_hi, msg_lo}, 32'h0);

        // R2 idle cycles change nothing
        repeat (3) @(negedge clk);
        check(msg_hi == 16'h0 && msg_lo == 16'h0, "R2 idle", {msg_hi, msg_lo}, 32'h0);

        for (int e = 0; e < 256; e++) begin
            logic [14:0] d;
            d = 15'((e * 1237 + 5) % 32768);
            exp_hi = {d, 1'b1};
            exp_lo = (16'(e) << 8) | 16'h0080;

            for (int z = 0; z < e % 4; z++) begin
                send_bit(1'b0);
            end
            if (e % 4 != 0) begin
                // R4 sentinel loaded by leading-zero shifts; R3 zeros keep high word clear
                check(msg_lo == 16'h8000, "R4 sentinel", msg_lo, 16'h8000);
                check(msg_hi == 16'h0, "R3 zero fill", msg_hi, 16'h0);
            end
            send_bit(1'b1);
            if (e % 5 == 0) begin
                hold_hi = msg_hi;
                pulse_clr();
                // R9 clear in HUNT ignored
                check(msg_hi == hold_hi && msg_lo == 16'h8000, "R9 clr in hunt", msg_hi, hold_hi);
            end
            for (int k = 0; k < 15; k++) begin
                send_bit(d[k]);
            end
            // R3 high word full, R4 sentinel in place
            check(msg_hi == exp_hi, "R3 high word", msg_hi, exp_hi);
            check(msg_lo == 16'h8000, "R4 sentinel", msg_lo, 16'h8000);

            for (int k = 0; k < 7; k++) begin
                send_bit(e[k]);
                if (e % 7 == 3 && k == 2) begin
                    pulse_clr(); // R9 clear in TAIL ignored
                end
            end
            // R5 high word frozen, no completion yet
            check(msg_hi == exp_hi && !msg_valid, "R5 tail fill", {msg_hi, 15'h0, msg_valid}, {exp_hi, 16'h0});
            send_bit(e[7]);
            // R6 completion
            check(msg_valid == 1'b1, "R6 valid rise", msg_valid, 1);
            check(msg_lo == exp_lo && msg_hi == exp_hi, "R6 words", {msg_hi, msg_lo}, {exp_hi, exp_lo});
            @(negedge clk);
            check(msg_valid == 1'b0, "R6 valid one cycle", msg_valid, 0);

            // R7 strobes ignored while posted
            send_bit(1'b1);
            send_bit(1'b0);
            check(msg_hi == exp_hi && msg_lo == exp_lo && !msg_valid, "R7 hold",
                  {msg_hi, msg_lo}, {exp_hi, exp_lo});

            pulse_clr();
            // R8 restart
            check(msg_hi == 16'h0 && msg_lo == exp_lo, "R8 clear", {msg_hi, msg_lo}, {16'h0, exp_lo});
        end

        // R1 reset in the middle of a message
        send_bit(1'b1);
        send_bit(1'b1);
        send_bit(1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(msg_hi == 16'h0 && msg_lo == 16'h0 && !msg_valid, "R1 mid reset", {msg_hi, msg_lo}, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule